// File: doc/BRIEF.md
# Atomic Reservation and Conflict Arbiter

This per-core unit runs the atomic side of a load/store pipeline against a simple ownership handshake. It holds one linked-load reservation and executes store-conditional and compare-and-swap requests. Linked loads and compare-and-swaps both raise the same fetch-for-ownership request. The unit records whether exclusive ownership came back and reports success or failure on a one-bit status.

A linked load never reports failure, even when ownership is refused. The refusal is kept in the reservation, and the store-conditional that follows reports it. A compare-and-swap fails as soon as ownership is refused.

Snoops from other agents are answered in the same cycle. A snoop that gives up a reserved line kills the reservation. When the snooper and this core are both in the middle of an atomic sequence on the same line, the 2-bit thread priorities decide which side continues; on a tie the current holder keeps the line. From the linked load until the store-conditional, the unit raises a strict-ordering flag.

Top module: `atomic_resv_unit`

## Requirements
- R1: Opcode `req_op_i` 2'b00 is a linked load and 2'b10 is a compare-and-swap. Each is accepted only while `req_ready_o` is 1. Each raises `fetch_valid_o` from the cycle after acceptance, with `fetch_line_o` = address bits [AW-1:LW] and `fetch_prio_o` = the request priority. Both outputs are held until `fetch_done_i`, and `req_ready_o` stays 0 for that whole time.
- R2: A linked load responds with `rsp_valid_o`=1 and `rsp_ok_o`=1 one cycle after `fetch_done_i`, with `rsp_data_o` = `fetch_data_i`, whether `fetch_excl_i` is 1 or 0. No write is made.
- R3: A store-conditional (opcode 2'b01) responds one cycle after acceptance. `rsp_ok_o` is 1 only if the reservation is valid, its ownership was granted, and its line equals the store line. On success `wr_valid_o`, `wr_addr_o` and `wr_data_o` are presented in that same cycle. Success or failure, the reservation is cleared.
- R4: A compare-and-swap responds one cycle after `fetch_done_i`. If ownership was refused, it fails with no write. If ownership was granted and the loaded data equals the compare value, it succeeds and writes the swap value. Otherwise it fails with `rsp_data_o` = the loaded data and no write.
- R5: A snoop to a line that is not reserved, or a snoop with `snp_atomic_i`=0, is always answered with `snp_give_o`=1. A give that hits the reserved line invalidates the reservation.
- R6: An atomic snoop to a reserved line held with ownership is refused (`snp_give_o`=0) when the holder priority is greater than or equal to `snp_prio_i`. The reservation then survives. Otherwise the snoop is given and the reservation is lost.
- R7: `strict_o` rises the cycle after a linked load is accepted and falls the cycle after a store-conditional is accepted. Compare-and-swap requests and snoops leave it unchanged.
- R8: After reset, `req_ready_o`=1, `strict_o`=0, no response, fetch or write is active, and the reservation is invalid, so a first store-conditional fails.
- R9: A new linked load replaces any older reservation, so a store-conditional to the older line fails.
- R10: Opcode 2'b11 is accepted and produces no fetch, response or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | 00 linked load, 01 store-conditional, 10 compare-and-swap, 11 none |
| req_addr_i | input | AW | Byte address |
| req_cmp_i | input | DW | Compare value for compare-and-swap |
| req_wdata_i | input | DW | Store or swap value |
| req_prio_i | input | PW | Thread priority |
| req_ready_o | output | 1 | Unit can accept a request |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_ok_o | output | 1 | Success status |
| rsp_data_o | output | DW | Loaded data |
| wr_valid_o | output | 1 | Line write pulse |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data |
| fetch_valid_o | output | 1 | Fetch-for-ownership request |
| fetch_line_o | output | AW-LW | Requested line |
| fetch_prio_o | output | PW | Requester priority |
| fetch_done_i | input | 1 | Fetch complete |
| fetch_excl_i | input | 1 | Exclusive ownership granted |
| fetch_data_i | input | DW | Fetched data |
| snp_valid_i | input | 1 | Snoop from another agent |
| snp_line_i | input | AW-LW | Snooped line |
| snp_atomic_i | input | 1 | Snooper is starting an atomic sequence |
| snp_prio_i | input | PW | Snooper priority |
| snp_give_o | output | 1 | Line surrendered (0 = refused) |
| strict_o | output | 1 | Strict ordering mode |

## Verification
The hardest state to reach is a priority conflict. It needs a live reservation that was granted ownership and an atomic snoop to exactly that line, at a priority below, equal to and above the holder's. The stimulus first completes a granted linked load at a chosen priority. It then sends atomic snoops at each relative priority and finishes with a store-conditional, whose status shows whether the reservation survived. Refused-ownership linked loads use the same sequence to show that the failure only appears at the store-conditional.

// File: rtl/atm_pkg.sv
package atm_pkg;
  typedef enum logic [1:0] {
    OP_LL   = 2'b00,
    OP_SC   = 2'b01,
    OP_CAS  = 2'b10,
    OP_NONE = 2'b11
  } atm_op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } atm_st_e;
endpackage

// File: rtl/atm_resv.sv
module atm_resv #(
  parameter int AW = 32,
  parameter int LW = 6,
  parameter int PW = 2,
  localparam int LAW = AW - LW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ll_start_i,
  input  logic           sc_take_i,
  input  logic           kill_i,
  input  logic           ll_fill_i,
  input  logic [LAW-1:0] fill_line_i,
  input  logic           fill_excl_i,
  input  logic [PW-1:0]  fill_prio_i,
  output logic           vld_o,
  output logic           excl_o,
  output logic [LAW-1:0] line_o,
  output logic [PW-1:0]  prio_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      excl_o <= 1'b0;
      line_o <= '0;
      prio_o <= '0;
    end else if (ll_fill_i) begin
      vld_o  <= 1'b1;
      excl_o <= fill_excl_i;
      line_o <= fill_line_i;
      prio_o <= fill_prio_i;
    end else if (ll_start_i || sc_take_i || kill_i) begin
      vld_o  <= 1'b0;
    end
  end

  a_r5_kill_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i && !ll_fill_i |=> !vld_o);
  a_r9_fill_replaces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ll_fill_i |=> vld_o && line_o == $past(fill_line_i));
  a_r3_sc_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_take_i && !ll_fill_i |=> !vld_o);
endmodule

// File: rtl/atm_snoop_arb.sv
module atm_snoop_arb #(
  parameter int AW = 32,
  parameter int LW = 6,
  parameter int PW = 2,
  localparam int LAW = AW - LW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           snp_valid_i,
  input  logic [LAW-1:0] snp_line_i,
  input  logic           snp_atomic_i,
  input  logic [PW-1:0]  snp_prio_i,
  input  logic           resv_vld_i,
  input  logic           resv_excl_i,
  input  logic [LAW-1:0] resv_line_i,
  input  logic [PW-1:0]  resv_prio_i,
  output logic           give_o,
  output logic           kill_o
);
  logic hit, contest, refuse;

  assign hit     = resv_vld_i && (resv_line_i == snp_line_i);
  // both sides mid-atomic on one owned line: priority decides, holder wins ties
  assign contest = hit && resv_excl_i && snp_atomic_i;
  assign refuse  = contest && (resv_prio_i >= snp_prio_i);
  assign give_o  = snp_valid_i && !refuse;
  assign kill_o  = snp_valid_i && hit && !refuse;

  a_r5_miss_gives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && (!resv_vld_i || !snp_atomic_i) |-> give_o);
  a_r6_higher_snooper_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && (snp_prio_i > resv_prio_i) |-> give_o);
  a_r6_refuse_keeps_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && !give_o |-> !kill_o && resv_vld_i);
endmodule

// File: rtl/atm_seq.sv
module atm_seq
  import atm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 6,
  parameter int PW = 2,
  localparam int LAW = AW - LW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [1:0]     req_op_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [DW-1:0]  req_cmp_i,
  input  logic [DW-1:0]  req_wdata_i,
  input  logic [PW-1:0]  req_prio_i,
  output logic           req_ready_o,
  output logic           rsp_valid_o,
  output logic           rsp_ok_o,
  output logic [DW-1:0]  rsp_data_o,
  output logic           wr_valid_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [DW-1:0]  wr_data_o,
  output logic           fetch_valid_o,
  output logic [LAW-1:0] fetch_line_o,
  output logic [PW-1:0]  fetch_prio_o,
  input  logic           fetch_done_i,
  input  logic           fetch_excl_i,
  input  logic [DW-1:0]  fetch_data_i,
  output logic           strict_o,
  input  logic           resv_vld_i,
  input  logic           resv_excl_i,
  input  logic [LAW-1:0] resv_line_i,
  output logic           ll_start_o,
  output logic           sc_take_o,
  output logic           ll_fill_o,
  output logic [LAW-1:0] fill_line_o,
  output logic           fill_excl_o,
  output logic [PW-1:0]  fill_prio_o
);
  atm_st_e         st_q;
  atm_op_e         op_q, req_op;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   cmp_q, wdata_q;
  logic [PW-1:0]   prio_q;
  logic            accept, done, sc_ok, cas_ok, needs_fetch;

  assign req_op      = atm_op_e'(req_op_i);
  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign needs_fetch = (req_op == OP_LL) || (req_op == OP_CAS);
  assign ll_start_o  = accept && (req_op == OP_LL);
  assign sc_take_o   = accept && (req_op == OP_SC);
  assign done        = (st_q == ST_FETCH) && fetch_done_i;

  assign sc_ok  = resv_vld_i && resv_excl_i && (resv_line_i == req_addr_i[AW-1:LW]);
  assign cas_ok = fetch_excl_i && (fetch_data_i == cmp_q);

  assign fetch_valid_o = (st_q == ST_FETCH);
  assign fetch_line_o  = addr_q[AW-1:LW];
  assign fetch_prio_o  = prio_q;

  // linked load completes silently; refusal is parked in the reservation
  assign ll_fill_o   = done && (op_q == OP_LL);
  assign fill_line_o = addr_q[AW-1:LW];
  assign fill_excl_o = fetch_excl_i;
  assign fill_prio_o = prio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      addr_q  <= '0;
      cmp_q   <= '0;
      wdata_q <= '0;
      prio_q  <= '0;
    end else begin
      if (accept) begin
        op_q    <= req_op;
        addr_q  <= req_addr_i;
        cmp_q   <= req_cmp_i;
        wdata_q <= req_wdata_i;
        prio_q  <= req_prio_i;
      end
      if (accept && needs_fetch) st_q <= ST_FETCH;
      else if (done)             st_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_data_o  <= '0;
      wr_valid_o  <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
    end else begin
      rsp_valid_o <= sc_take_o || done;
      wr_valid_o  <= (sc_take_o && sc_ok) || (done && (op_q == OP_CAS) && cas_ok);
      if (sc_take_o) begin
        rsp_ok_o   <= sc_ok;
        rsp_data_o <= '0;
        wr_addr_o  <= req_addr_i;
        wr_data_o  <= req_wdata_i;
      end else if (done) begin
        rsp_ok_o   <= (op_q == OP_LL) ? 1'b1 : cas_ok;
        rsp_data_o <= fetch_data_i;
        wr_addr_o  <= addr_q;
        wr_data_o  <= wdata_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         strict_o <= 1'b0;
    else if (ll_start_o) strict_o <= 1'b1;
    else if (sc_take_o)  strict_o <= 1'b0;
  end

  a_r3_write_needs_success: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> rsp_valid_o && rsp_ok_o);
  a_r1_fetch_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o && !fetch_done_i |=> fetch_valid_o && $stable(fetch_line_o) && !req_ready_o);
  a_r2_ll_never_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ll_fill_o |=> rsp_valid_o && rsp_ok_o && !wr_valid_o);
  a_r4_cas_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && (op_q == OP_CAS) && !fetch_excl_i |=> rsp_valid_o && !rsp_ok_o && !wr_valid_o);
  a_r7_strict_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strict_o) |-> $past(ll_start_o));
  a_r7_strict_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strict_o) |-> $past(sc_take_o));
  a_r10_nop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (req_op == OP_NONE) |=> !rsp_valid_o && !fetch_valid_o && !wr_valid_o);
endmodule

// File: rtl/atomic_resv_unit.sv
module atomic_resv_unit #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 6,
  parameter int PW = 2,
  localparam int LAW = AW - LW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [1:0]     req_op_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [DW-1:0]  req_cmp_i,
  input  logic [DW-1:0]  req_wdata_i,
  input  logic [PW-1:0]  req_prio_i,
  output logic           req_ready_o,
  output logic           rsp_valid_o,
  output logic           rsp_ok_o,
  output logic [DW-1:0]  rsp_data_o,
  output logic           wr_valid_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [DW-1:0]  wr_data_o,
  output logic           fetch_valid_o,
  output logic [LAW-1:0] fetch_line_o,
  output logic [PW-1:0]  fetch_prio_o,
  input  logic           fetch_done_i,
  input  logic           fetch_excl_i,
  input  logic [DW-1:0]  fetch_data_i,
  input  logic           snp_valid_i,
  input  logic [LAW-1:0] snp_line_i,
  input  logic           snp_atomic_i,
  input  logic [PW-1:0]  snp_prio_i,
  output logic           snp_give_o,
  output logic           strict_o
);
  logic           resv_vld, resv_excl;
  logic [LAW-1:0] resv_line;
  logic [PW-1:0]  resv_prio;
  logic           ll_start, sc_take, ll_fill, fill_excl, kill;
  logic [LAW-1:0] fill_line;
  logic [PW-1:0]  fill_prio;

  atm_seq #(.AW(AW), .DW(DW), .LW(LW), .PW(PW)) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_op_i, .req_addr_i, .req_cmp_i, .req_wdata_i, .req_prio_i,
    .req_ready_o,
    .rsp_valid_o, .rsp_ok_o, .rsp_data_o,
    .wr_valid_o, .wr_addr_o, .wr_data_o,
    .fetch_valid_o, .fetch_line_o, .fetch_prio_o,
    .fetch_done_i, .fetch_excl_i, .fetch_data_i,
    .strict_o,
    .resv_vld_i  (resv_vld),
    .resv_excl_i (resv_excl),
    .resv_line_i (resv_line),
    .ll_start_o  (ll_start),
    .sc_take_o   (sc_take),
    .ll_fill_o   (ll_fill),
    .fill_line_o (fill_line),
    .fill_excl_o (fill_excl),
    .fill_prio_o (fill_prio)
  );

  atm_resv #(.AW(AW), .LW(LW), .PW(PW)) u_resv (
    .clk_i, .rst_ni,
    .ll_start_i  (ll_start),
    .sc_take_i   (sc_take),
    .kill_i      (kill),
    .ll_fill_i   (ll_fill),
    .fill_line_i (fill_line),
    .fill_excl_i (fill_excl),
    .fill_prio_i (fill_prio),
    .vld_o       (resv_vld),
    .excl_o      (resv_excl),
    .line_o      (resv_line),
    .prio_o      (resv_prio)
  );

  atm_snoop_arb #(.AW(AW), .LW(LW), .PW(PW)) u_arb (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_line_i, .snp_atomic_i, .snp_prio_i,
    .resv_vld_i  (resv_vld),
    .resv_excl_i (resv_excl),
    .resv_line_i (resv_line),
    .resv_prio_i (resv_prio),
    .give_o      (snp_give_o),
    .kill_o      (kill)
  );
endmodule

// File: tb/atomic_resv_unit_tb.sv
module atomic_resv_unit_tb;
  localparam int AW = 32, DW = 32, LW = 6, PW = 2, LAW = AW - LW;
  localparam logic [1:0] LL = 2'b00, SC = 2'b01, CAS = 2'b10, NOP = 2'b11;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 0; logic [1:0] req_op = 0; logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_cmp = 0, req_wdata = 0; logic [PW-1:0] req_prio = 0;
  logic req_ready, rsp_valid, rsp_ok, wr_valid, fetch_valid, snp_give, strict;
  logic [DW-1:0] rsp_data, wr_data; logic [AW-1:0] wr_addr;
  logic [LAW-1:0] fetch_line; logic [PW-1:0] fetch_prio;
  logic fetch_done = 0, fetch_excl = 0; logic [DW-1:0] fetch_data = 0;
  logic snp_valid = 0, snp_atomic = 0; logic [LAW-1:0] snp_line = 0; logic [PW-1:0] snp_prio = 0;

  int errors = 0, checks = 0;
  bit running = 0;
  // reference model state
  bit m_vld = 0, m_excl = 0, m_strict = 0, m_ready = 1, m_rsp = 0, m_wr = 0, m_fetch = 0;
  logic [LAW-1:0] m_line = 0; int m_prio = 0;

  always #10 clk = ~clk;

  atomic_resv_unit #(.AW(AW), .DW(DW), .LW(LW), .PW(PW)) u_dut (
    .clk_i(clk), .rst_ni,
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_cmp_i(req_cmp), .req_wdata_i(req_wdata), .req_prio_i(req_prio),
    .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok), .rsp_data_o(rsp_data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .fetch_valid_o(fetch_valid), .fetch_line_o(fetch_line), .fetch_prio_o(fetch_prio),
    .fetch_done_i(fetch_done), .fetch_excl_i(fetch_excl), .fetch_data_i(fetch_data),
    .snp_valid_i(snp_valid), .snp_line_i(snp_line), .snp_atomic_i(snp_atomic),
    .snp_prio_i(snp_prio), .snp_give_o(snp_give), .strict_o(strict)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic logic [LAW-1:0] line_of(input logic [AW-1:0] a);
    return a[AW-1:LW];
  endfunction

  // per-clock comparison against the model, late in the cycle
  always @(posedge clk) begin
    #15;
    if (running) begin
      chk(strict == m_strict, "R7 strict_o per clock", strict, m_strict);
      chk(req_ready == m_ready, "R1 req_ready_o per clock", req_ready, m_ready);
      chk(fetch_valid == m_fetch, "R1 fetch_valid_o per clock", fetch_valid, m_fetch);
      chk(rsp_valid == m_rsp, "R2 rsp_valid_o per clock", rsp_valid, m_rsp);
      chk(wr_valid == m_wr, "R3 wr_valid_o per clock", wr_valid, m_wr);
    end
  end

  task automatic do_sc(input logic [AW-1:0] a, input logic [DW-1:0] wv, input string tag);
    bit exp_ok;
    @(negedge clk);
    req_valid = 1; req_op = SC; req_addr = a; req_wdata = wv;
    @(negedge clk);
    req_valid = 0;
    exp_ok = m_vld && m_excl && (m_line == line_of(a));
    m_vld = 0; m_strict = 0; m_rsp = 1; m_wr = exp_ok;
    chk(rsp_ok == exp_ok, {tag, " R3 sc status"}, rsp_ok, exp_ok);
    if (exp_ok) begin
      chk(wr_addr == a, {tag, " R3 sc write addr"}, wr_addr, a);
      chk(wr_data == wv, {tag, " R3 sc write data"}, wr_data, wv);
    end
    @(negedge clk);
    m_rsp = 0; m_wr = 0;
  endtask

  task automatic fetch_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] cv,
                          input logic [DW-1:0] wv, input int pr, input bit ex,
                          input logic [DW-1:0] ld, input int dly, input string tag);
    bit exp_ok, exp_wr;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_cmp = cv; req_wdata = wv; req_prio = PW'(pr);
    @(negedge clk);
    req_valid = 0; m_ready = 0; m_fetch = 1;
    if (op == LL) begin m_strict = 1; m_vld = 0; end
    chk(fetch_line == line_of(a), {tag, " R1 fetch line"}, fetch_line, line_of(a));
    chk(fetch_prio == PW'(pr), {tag, " R1 fetch prio"}, fetch_prio, pr);
    repeat (dly) @(negedge clk);
    fetch_done = 1; fetch_excl = ex; fetch_data = ld;
    @(negedge clk);
    fetch_done = 0; fetch_excl = 0; fetch_data = 0;
    m_ready = 1; m_fetch = 0; m_rsp = 1;
    if (op == LL) begin
      exp_ok = 1; exp_wr = 0;
      m_vld = 1; m_excl = ex; m_line = line_of(a); m_prio = pr;
    end else begin
      exp_ok = ex && (ld == cv); exp_wr = exp_ok;
    end
    m_wr = exp_wr;
    chk(rsp_ok == exp_ok, {tag, (op == LL) ? " R2 ll status" : " R4 cas status"}, rsp_ok, exp_ok);
    if (op == LL || ex)
      chk(rsp_data == ld, {tag, (op == LL) ? " R2 ll data" : " R4 cas data"}, rsp_data, ld);
    if (exp_wr) begin
      chk(wr_addr == a, {tag, " R4 cas write addr"}, wr_addr, a);
      chk(wr_data == wv, {tag, " R4 cas write data"}, wr_data, wv);
    end
    @(negedge clk);
    m_rsp = 0; m_wr = 0;
  endtask

  task automatic do_snoop(input logic [AW-1:0] a, input bit atomic, input int pr, input string tag);
    bit hit, exp_give;
    @(negedge clk);
    snp_valid = 1; snp_line = line_of(a); snp_atomic = atomic; snp_prio = PW'(pr);
    #1;
    hit = m_vld && (m_line == line_of(a));
    exp_give = !(hit && m_excl && atomic && (m_prio >= pr));
    chk(snp_give == exp_give, {tag, " R6 snoop give"}, snp_give, exp_give);
    @(negedge clk);
    snp_valid = 0; snp_atomic = 0;
    if (hit && exp_give) m_vld = 0;
  endtask

  localparam logic [AW-1:0] A = 32'h0000_1040, A2 = 32'h0000_1078, B = 32'h0000_2200, C = 32'h0000_3300;

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R8 reset state
    chk(req_ready == 1, "R8 ready after reset", req_ready, 1);
    chk(strict == 0, "R8 strict after reset", strict, 0);
    chk(!rsp_valid && !wr_valid && !fetch_valid, "R8 idle outputs", {rsp_valid, wr_valid, fetch_valid}, 0);
    running = 1;
    do_sc(A, 32'h11, "R8 first sc");

    // granted linked load, conditional store in the same line (different byte)
    fetch_op(LL, A, 0, 0, 1, 1, 32'hAAAA_0001, 0, "R2 granted");
    do_sc(A2, 32'h22, "R3 match");
    // refused linked load: silent, failure surfaces at store
    fetch_op(LL, A, 0, 0, 1, 0, 32'hAAAA_0002, 3, "R2 refused");
    do_sc(A, 32'h33, "R3 deferred fail");
    // line mismatch
    fetch_op(LL, A, 0, 0, 0, 1, 32'h5, 1, "R3 setup");
    do_sc(B, 32'h44, "R3 wrong line");

    // compare-and-swap cases
    fetch_op(CAS, B, 32'h7, 32'h70, 0, 0, 32'h7, 2, "R4 refused");
    fetch_op(CAS, B, 32'h7, 32'h71, 0, 1, 32'h7, 0, "R4 match");
    fetch_op(CAS, B, 32'h7, 32'h72, 0, 1, 32'h9, 1, "R4 mismatch");

    // snoops: other line and plain snoop
    fetch_op(LL, A, 0, 0, 2, 1, 32'h1, 0, "R5 setup");
    do_snoop(B, 1, 3, "R5 other line");
    do_sc(A, 32'h55, "R5 survives other line");
    fetch_op(LL, A, 0, 0, 3, 1, 32'h1, 0, "R5 setup2");
    do_snoop(A, 0, 0, "R5 plain hit");
    do_sc(A, 32'h56, "R5 killed by plain snoop");

    // priority conflicts
    fetch_op(LL, A, 0, 0, 2, 1, 32'h1, 0, "R6 setup");
    do_snoop(A, 1, 1, "R6 lower snooper");
    do_snoop(A, 1, 2, "R6 equal snooper");
    do_sc(A, 32'h57, "R6 holder kept line");
    fetch_op(LL, A, 0, 0, 1, 1, 32'h1, 0, "R6 setup2");
    do_snoop(A, 1, 3, "R6 higher snooper");
    do_sc(A, 32'h58, "R6 holder lost line");
    // refused reservation is not defended
    fetch_op(LL, A, 0, 0, 3, 0, 32'h1, 0, "R6 setup3");
    do_snoop(A, 1, 0, "R6 unowned line");

    // R9 replacement
    fetch_op(LL, A, 0, 0, 1, 1, 32'h1, 0, "R9 first");
    fetch_op(LL, B, 0, 0, 1, 1, 32'h2, 0, "R9 second");
    do_sc(A, 32'h59, "R9 old line fails");
    fetch_op(LL, A, 0, 0, 1, 1, 32'h1, 0, "R9 first b");
    fetch_op(LL, B, 0, 0, 1, 1, 32'h2, 0, "R9 second b");
    do_sc(B, 32'h5A, "R9 new line ok");

    // R7 CAS inside the window leaves strict and reservation alone
    fetch_op(LL, A, 0, 0, 1, 1, 32'h1, 0, "R7 setup");
    fetch_op(CAS, C, 32'h3, 32'h4, 1, 1, 32'h3, 1, "R7 cas in window");
    chk(strict == 1, "R7 strict held across cas", strict, 1);
    do_sc(A, 32'h5B, "R7 sc after cas");
    chk(strict == 0, "R7 strict dropped", strict, 0);

    // R10 unused opcode
    @(negedge clk);
    req_valid = 1; req_op = NOP; req_addr = A;
    @(negedge clk);
    req_valid = 0;
    chk(!rsp_valid && !fetch_valid && !wr_valid, "R10 nop silent", {rsp_valid, fetch_valid, wr_valid}, 0);
    repeat (2) @(negedge clk);

    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule